// File: doc/BRIEF.md
# Frame-Aligned Capture FIFO Pair with Clear Control

This block holds the two capture queues of an image sensor front end: a wide receive queue for pixel words and a narrow queue for per-frame status bytes. It also decides when each queue is emptied. A single configuration bit selects one of two clear policies. In frame-locked mode, every start-of-frame pulse empties both queues on its own, and software does not take part. In immediate mode, each queue has a write-one strobe that empties that queue in the cycle it is raised.

The two queues come back from an immediate clear differently. The receive queue takes new words from the very next cycle. The status queue stays empty and refuses writes until the next start-of-frame pulse, so status bytes never straddle a frame boundary. The start-of-frame input is a single-cycle pulse, derived upstream from the rising edge of vertical sync in the same clock domain. The mode bit is meant to be set once at start-up and left alone during capture.

Both queues are first-word fall-through: the read data port shows the oldest entry whenever the queue is not empty, and a read strobe pops it.

Top module: `sof_fifo_clear`

## Requirements
- R1: With sync_mode = 1, a cycle with sof = 1 empties both queues: rx_empty and st_empty are 1 in the following cycle, and any write offered in that sof cycle is dropped.
- R2: With sync_mode = 1, rx_clr and st_clr have no effect: contents, flags and read data stay as they would be without the strobe, and rx_enabled stays 1 outside sof cycles.
- R3: With sync_mode = 0, rx_clr = 1 empties only the receive queue and st_clr = 1 empties only the status queue, with the empty flag set in the cycle after the strobe and the other queue left unchanged.
- R4: With sync_mode = 0, the receive queue accepts a write in the cycle right after rx_clr, and rx_enabled is 1 there.
- R5: With sync_mode = 0, after st_clr the status queue stays empty, st_enabled is 0 and writes are ignored until a cycle with sof = 1. From that sof cycle onward, writes are accepted again.
- R6: A clear and a write to the same queue in the same cycle leave the queue empty; the write is discarded. The enabled output of that queue is 0 in any cycle where it is being cleared.
- R7: With sync_mode = 0, st_clr and sof in the same cycle empty the status queue but leave it enabled, so it accepts a write in the next cycle.
- R8: The receive queue is 32 bits wide and 16 entries deep, and the status queue is 8 bits wide and 8 entries deep. Both deliver data in write order. The full flag is 1 when the queue holds its depth. A write while full and a read while empty are ignored.
- R9: After reset, both queues are empty and not full, and both enabled outputs are 1.
- R10: With sync_mode = 0, a sof pulse without a clear strobe leaves both queues' contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sof | input | 1 | Start-of-frame pulse, one cycle |
| sync_mode | input | 1 | 1 = clear on every sof, 0 = clear on software strobe |
| rx_clr | input | 1 | Write-one clear strobe for the receive queue |
| st_clr | input | 1 | Write-one clear strobe for the status queue |
| rx_wr | input | 1 | Receive queue write request |
| rx_wdata | input | 32 | Receive queue write data |
| rx_rd | input | 1 | Receive queue read (pop) |
| rx_rdata | output | 32 | Oldest receive entry |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_enabled | output | 1 | Receive queue accepts writes this cycle |
| st_wr | input | 1 | Status queue write request |
| st_wdata | input | 8 | Status queue write data |
| st_rd | input | 1 | Status queue read (pop) |
| st_rdata | output | 8 | Oldest status entry |
| st_empty | output | 1 | Status queue empty |
| st_full | output | 1 | Status queue full |
| st_enabled | output | 1 | Status queue accepts writes this cycle |

## Verification
On every cycle, the assertions check the following: a frame-locked sof or an immediate strobe leaves the cleared queue empty one cycle later, the receive queue is enabled again right after its strobe, a disabled status queue stays empty, and no queue ever reports full and empty together. Some behaviours need stored history, so only the bench's scenarios, run against its queue model, can show them. These are that ignored strobes in frame-locked mode keep the stored data intact, that writes during the status hold really vanish, that data comes out in order, and that a sof in immediate mode leaves the contents alone.

// File: rtl/sof_fifo_clear_pkg.sv
package sof_fifo_clear_pkg;

    localparam int RX_W_DEF = 32;
    localparam int RX_D_DEF = 16;
    localparam int ST_W_DEF = 8;
    localparam int ST_D_DEF = 8;

    typedef enum logic {
        MODE_IMMEDIATE = 1'b0,
        MODE_FRAME     = 1'b1
    } clr_mode_e;

    // per-queue control produced by the clear controller
    typedef struct packed {
        logic flush;
        logic enable;
    } lane_ctl_t;

    function automatic int unsigned wrap_inc(input int unsigned ptr, input int unsigned depth);
        return (ptr == depth - 1) ? 0 : ptr + 1;
    endfunction

endpackage

// File: rtl/sof_clr_ctrl.sv
module sof_clr_ctrl
    import sof_fifo_clear_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sof,
    input  logic      sync_mode,
    input  logic      rx_clr,
    input  logic      st_clr,
    output lane_ctl_t rx_ctl,
    output lane_ctl_t st_ctl
);
    clr_mode_e mode;
    logic      st_hold;

    assign mode = clr_mode_e'(sync_mode);

    always_comb begin
        if (mode == MODE_FRAME) begin
            rx_ctl.flush = sof;
            st_ctl.flush = sof;
        end else begin
            rx_ctl.flush = rx_clr;
            st_ctl.flush = st_clr;
        end
        rx_ctl.enable = ~rx_ctl.flush;
        st_ctl.enable = ~st_ctl.flush & (~st_hold | sof);
    end

    // status queue stays frozen after an immediate clear until next frame start
    always_ff @(posedge clk) begin
        if (rst)
            st_hold <= 1'b0;
        else if (sof)
            st_hold <= 1'b0;
        else if (mode == MODE_IMMEDIATE && st_clr)
            st_hold <= 1'b1;
    end
endmodule

// File: rtl/sof_clr_fifo.sv
module sof_clr_fifo
    import sof_fifo_clear_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             wr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             rd,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [CW-1:0]    cnt;
    logic             do_wr, do_rd;

    assign empty = (cnt == '0);
    assign full  = (cnt == CW'(DEPTH));
    assign do_wr = wr & ~full & ~flush;
    assign do_rd = rd & ~empty & ~flush;
    assign rdata = mem[rp];

    always_ff @(posedge clk) begin
        if (do_wr)
            mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_wr)
                wp <= AW'(wrap_inc(int'(wp), DEPTH));
            if (do_rd)
                rp <= AW'(wrap_inc(int'(rp), DEPTH));
            cnt <= cnt + CW'(do_wr) - CW'(do_rd);
        end
    end
endmodule

// File: rtl/sof_fifo_clear.sv
module sof_fifo_clear
    import sof_fifo_clear_pkg::*;
#(
    parameter int RX_WIDTH = RX_W_DEF,
    parameter int RX_DEPTH = RX_D_DEF,
    parameter int ST_WIDTH = ST_W_DEF,
    parameter int ST_DEPTH = ST_D_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sof,
    input  logic                sync_mode,
    input  logic                rx_clr,
    input  logic                st_clr,
    input  logic                rx_wr,
    input  logic [RX_WIDTH-1:0] rx_wdata,
    input  logic                rx_rd,
    output logic [RX_WIDTH-1:0] rx_rdata,
    output logic                rx_empty,
    output logic                rx_full,
    output logic                rx_enabled,
    input  logic                st_wr,
    input  logic [ST_WIDTH-1:0] st_wdata,
    input  logic                st_rd,
    output logic [ST_WIDTH-1:0] st_rdata,
    output logic                st_empty,
    output logic                st_full,
    output logic                st_enabled
);
    lane_ctl_t rx_ctl, st_ctl;

    sof_clr_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .sof       (sof),
        .sync_mode (sync_mode),
        .rx_clr    (rx_clr),
        .st_clr    (st_clr),
        .rx_ctl    (rx_ctl),
        .st_ctl    (st_ctl)
    );

    sof_clr_fifo #(.WIDTH(RX_WIDTH), .DEPTH(RX_DEPTH)) u_rx (
        .clk   (clk),
        .rst   (rst),
        .flush (rx_ctl.flush),
        .wr    (rx_wr & rx_ctl.enable),
        .wdata (rx_wdata),
        .rd    (rx_rd),
        .rdata (rx_rdata),
        .empty (rx_empty),
        .full  (rx_full)
    );

    sof_clr_fifo #(.WIDTH(ST_WIDTH), .DEPTH(ST_DEPTH)) u_st (
        .clk   (clk),
        .rst   (rst),
        .flush (st_ctl.flush),
        .wr    (st_wr & st_ctl.enable),
        .wdata (st_wdata),
        .rd    (st_rd),
        .rdata (st_rdata),
        .empty (st_empty),
        .full  (st_full)
    );

    assign rx_enabled = rx_ctl.enable;
    assign st_enabled = st_ctl.enable;
endmodule

// File: rtl/sof_fifo_clear_chk.sv
module sof_fifo_clear_chk (
    input logic clk,
    input logic rst,
    input logic sof,
    input logic sync_mode,
    input logic rx_clr,
    input logic st_clr,
    input logic rx_empty,
    input logic rx_full,
    input logic rx_enabled,
    input logic st_empty,
    input logic st_full,
    input logic st_enabled
);
    AST_FRAME_FLUSH: assert property (@(posedge clk) disable iff (rst)
        (sync_mode && sof) |=> (rx_empty && st_empty));                      // R1
    AST_FRAME_RX_OPEN: assert property (@(posedge clk) disable iff (rst)
        (sync_mode && !sof) |-> rx_enabled);                                  // R2
    AST_RX_STROBE_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (!sync_mode && rx_clr) |=> rx_empty);                                 // R3
    AST_ST_STROBE_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (!sync_mode && st_clr) |=> st_empty);                                 // R3
    AST_RX_REOPEN: assert property (@(posedge clk) disable iff (rst)
        (!sync_mode && rx_clr) |=> (rx_enabled || rx_clr));                  // R4
    AST_ST_HELD_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (!st_enabled && !sof) |=> st_empty);                                  // R5
    AST_ST_SOF_REOPEN: assert property (@(posedge clk) disable iff (rst)
        (!sync_mode && st_clr && sof) |=> (st_enabled || st_clr || sof));     // R7
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        !(rx_full && rx_empty) && !(st_full && st_empty));                    // R8
endmodule

bind sof_fifo_clear sof_fifo_clear_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .sof        (sof),
    .sync_mode  (sync_mode),
    .rx_clr     (rx_clr),
    .st_clr     (st_clr),
    .rx_empty   (rx_empty),
    .rx_full    (rx_full),
    .rx_enabled (rx_enabled),
    .st_empty   (st_empty),
    .st_full    (st_full),
    .st_enabled (st_enabled)
);

// File: tb/sof_fifo_clear_test.sv
`timescale 1ns/1ps
module sof_fifo_clear_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sof = 1'b0, sync_mode = 1'b0, rx_clr = 1'b0, st_clr = 1'b0;
    logic        rx_wr = 1'b0, rx_rd = 1'b0, st_wr = 1'b0, st_rd = 1'b0;
    logic [31:0] rx_wdata = '0;
    logic [7:0]  st_wdata = '0;
    logic [31:0] rx_rdata;
    logic [7:0]  st_rdata;
    logic        rx_empty, rx_full, rx_enabled, st_empty, st_full, st_enabled;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string cur_req = "R9";

    logic [31:0] mrx[$];
    logic [7:0]  mst[$];
    bit          mhold = 0;

    always #4 clk = ~clk;

    sof_fifo_clear uut (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // reference model: state update at the clock edge
    always @(posedge clk) begin
        if (rst) begin
            mrx.delete(); mst.delete(); mhold = 0;
        end else begin
            bit frx, fst, sen;
            frx = sync_mode ? sof : rx_clr;
            fst = sync_mode ? sof : st_clr;
            sen = !fst && (!mhold || sof);
            if (frx) mrx.delete();
            else begin
                bit w;
                w = rx_wr && mrx.size() < 16;
                if (rx_rd && mrx.size() > 0) void'(mrx.pop_front());
                if (w) mrx.push_back(rx_wdata);
            end
            if (fst) mst.delete();
            else begin
                bit w;
                w = st_wr && sen && mst.size() < 8;
                if (st_rd && mst.size() > 0) void'(mst.pop_front());
                if (w) mst.push_back(st_wdata);
            end
            if (sof) mhold = 0;
            else if (!sync_mode && st_clr) mhold = 1;
        end
    end

    // comparison away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            bit erx, est;
            erx = !(sync_mode ? sof : rx_clr);
            est = !(sync_mode ? sof : st_clr) && (!mhold || sof);
            chk(rx_empty == (mrx.size() == 0), cur_req, "rx_empty", rx_empty, mrx.size() == 0);
            chk(rx_full == (mrx.size() == 16), cur_req, "rx_full", rx_full, mrx.size() == 16);
            chk(st_empty == (mst.size() == 0), cur_req, "st_empty", st_empty, mst.size() == 0);
            chk(st_full == (mst.size() == 8), cur_req, "st_full", st_full, mst.size() == 8);
            chk(rx_enabled == erx, cur_req, "rx_enabled", rx_enabled, erx);
            chk(st_enabled == est, cur_req, "st_enabled", st_enabled, est);
            if (mrx.size() > 0)
                chk(rx_rdata == mrx[0], cur_req, "rx_rdata", rx_rdata, mrx[0]);
            if (mst.size() > 0)
                chk(st_rdata == mst[0], cur_req, "st_rdata", st_rdata, mst[0]);
        end
    end

    task automatic step();
        @(posedge clk); #1;
        sof = 0; rx_clr = 0; st_clr = 0;
        rx_wr = 0; rx_rd = 0; st_wr = 0; st_rd = 0;
    endtask

    task automatic wr_both(input logic [31:0] d, input logic [7:0] s);
        rx_wr = 1; rx_wdata = d; st_wr = 1; st_wdata = s; step();
    endtask

    task automatic finish_run();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog run did not finish");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        #3;
        cur_req = "R9";
        chk(rx_empty && !rx_full && st_empty && !st_full, "R9", "reset flags",
            {rx_empty, rx_full, st_empty, st_full}, 4'b1010);
        chk(rx_enabled && st_enabled, "R9", "reset enables", {rx_enabled, st_enabled}, 2'b11);
        step();

        cur_req = "R8";
        for (int i = 0; i < 5; i++) wr_both(32'hA000_0000 + i, 8'h10 + 8'(i));
        rx_rd = 1; st_rd = 1; step();
        for (int i = 0; i < 14; i++) begin
            rx_wr = 1; rx_wdata = 32'hB000_0000 + i; st_wr = 1; st_wdata = 8'h40 + 8'(i); step();
        end
        #3 chk(rx_full && st_full, "R8", "both full", {rx_full, st_full}, 2'b11);
        for (int i = 0; i < 20; i++) begin rx_rd = 1; st_rd = 1; step(); end
        #3 chk(rx_empty && st_empty, "R8", "drained", {rx_empty, st_empty}, 2'b11);

        cur_req = "R10";
        for (int i = 0; i < 3; i++) wr_both(32'hC000_0000 + i, 8'h60 + 8'(i));
        sof = 1; step();
        #3 chk(!rx_empty && !st_empty, "R10", "sof keeps data", {rx_empty, st_empty}, 2'b00);

        cur_req = "R3";
        rx_clr = 1; step();
        #3 chk(rx_empty && !st_empty, "R3", "rx only cleared", {rx_empty, st_empty}, 2'b10);
        cur_req = "R4";
        chk(rx_enabled, "R4", "rx enabled after clear", rx_enabled, 1);
        rx_wr = 1; rx_wdata = 32'hD00D_0001; step();
        #3 chk(!rx_empty && rx_rdata == 32'hD00D_0001, "R4", "rx write after clear",
               rx_rdata, 32'hD00D_0001);

        cur_req = "R5";
        st_clr = 1; step();
        #3 chk(st_empty && !st_enabled && !rx_empty, "R5", "st held",
               {st_empty, st_enabled, rx_empty}, 3'b100);
        for (int i = 0; i < 4; i++) begin st_wr = 1; st_wdata = 8'hEE; step(); end
        #3 chk(st_empty, "R5", "held writes ignored", st_empty, 1);
        sof = 1; st_wr = 1; st_wdata = 8'h77; step();
        #3 chk(!st_empty && st_rdata == 8'h77 && st_enabled, "R5", "reopen at sof", st_rdata, 8'h77);

        cur_req = "R6";
        rx_clr = 1; rx_wr = 1; rx_wdata = 32'h1234_5678; step();
        #3 chk(rx_empty, "R6", "clear beats write", rx_empty, 1);

        cur_req = "R7";
        st_clr = 1; sof = 1; step();
        #3 chk(st_empty && st_enabled, "R7", "clear+sof stays enabled", {st_empty, st_enabled}, 2'b11);
        st_wr = 1; st_wdata = 8'h5A; step();
        #3 chk(!st_empty && st_rdata == 8'h5A, "R7", "write accepted", st_rdata, 8'h5A);

        cur_req = "R2";
        sync_mode = 1; step();
        for (int i = 0; i < 3; i++) wr_both(32'hE000_0000 + i, 8'h90 + 8'(i));
        rx_clr = 1; st_clr = 1; step();
        #3 chk(!rx_empty && !st_empty && rx_enabled, "R2", "strobes ignored",
               {rx_empty, st_empty, rx_enabled}, 3'b001);

        cur_req = "R1";
        sof = 1; rx_wr = 1; rx_wdata = 32'hFFFF_0000; st_wr = 1; step();
        #3 chk(rx_empty && st_empty, "R1", "frame flush", {rx_empty, st_empty}, 2'b11);

        // mixed random traffic in frame-locked then immediate mode
        for (int m = 0; m < 2; m++) begin
            sync_mode = (m == 0);
            cur_req = (m == 0) ? "R1" : "R3";
            for (int i = 0; i < 400; i++) begin
                sof = ($urandom_range(0, 29) == 0);
                rx_clr = ($urandom_range(0, 39) == 0);
                st_clr = ($urandom_range(0, 39) == 0);
                rx_wr = $urandom_range(0, 2) != 0; rx_wdata = $urandom();
                st_wr = $urandom_range(0, 2) != 0; st_wdata = 8'($urandom());
                rx_rd = $urandom_range(0, 1) != 0; st_rd = $urandom_range(0, 1) != 0;
                @(posedge clk); #1;
            end
            step();
        end
        step();
        finish_run();
    end
endmodule